// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Hardware Refill

This block caches virtual-to-physical page translations for a data path with 32-bit virtual and physical addresses and 4 KB pages. It holds 64 translations in 16 sets of 4 ways. A request is accepted with a valid/ready handshake. One cycle later a hit returns the physical address.

On a miss, an internal walker reads one 32-bit page table entry from a single-level table in memory. The table starts at a base address given on an input. If the entry is valid, the walker installs it and returns the translation. If it is invalid, the walker reports a fault. No software takes part in a miss.

Within a set, a victim is chosen in two steps. An empty way is taken first. When the set is full, a three-bit tree approximation of least-recently-used order picks the way. A flush input empties the whole buffer in one cycle and abandons any walk in progress.

Top module: `tlb_sa_refill`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_rd_valid is 0.
- R2: A request whose page is held produces rsp_valid=1, rsp_hit=1, rsp_fault=0 in the cycle after acceptance. The address returned is the stored physical page number joined to the 12-bit offset, and no memory read is issued.
- R3: On a miss, exactly one read is issued at ptbr + 4 × (vaddr[31:12]). mem_rd_valid and mem_rd_addr hold until mem_rd_ready, and req_ready stays 0 until the walk ends.
- R4: A page table entry with bit 0 set completes the miss in the same cycle as mem_rsp_valid, with rsp_hit=0, rsp_fault=0 and rsp_paddr = {entry[31:12], vaddr[11:0]}. A later access to that page hits.
- R5: A page table entry with bit 0 clear gives rsp_fault=1, rsp_hit=0 and rsp_paddr=0. Nothing is installed, so the next access to that page misses again.
- R6: The set is vaddr[15:12] and the tag is vaddr[31:16]. Four pages that share a set are all held at once.
- R7: A refill goes into the lowest-numbered invalid way of the set, if one exists.
- R8: Each set keeps a root bit and two leaf bits. Root 0 selects ways 0/1 and root 1 selects ways 2/3. The left leaf picks way 0 when 0 and way 1 when 1; the right leaf picks way 2 when 0 and way 3 when 1. Every hit and every refill sets the tree to point away from the way used. In a full set, the way the tree points to is replaced.
- R9: A flush clears all entries and all tree bits in one cycle, so every later access misses.
- R10: A flush during a walk gives no response and installs nothing. If the read was already accepted, req_ready stays 0 until its response arrives, and that response is discarded.
- R11: While flush is high, req_ready is 0 and no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries, abort walk |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| ptbr | input | 32 | Byte address of page table start |
| rsp_valid | output | 1 | Translation result valid (one cycle) |
| rsp_paddr | output | 32 | Physical address |
| rsp_hit | output | 1 | Result came from a held entry |
| rsp_fault | output | 1 | Page table entry was invalid |
| mem_rd_valid | output | 1 | Page table read request |
| mem_rd_ready | input | 1 | Memory accepts read request |
| mem_rd_addr | output | 32 | Byte address of page table entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Page table entry |

## Verification
Every fault inside the block shows up at the ports within one or two requests.

- **Corrupted tree bits:** the wrong page is evicted. This surfaces as an unexpected memory read on the next access to a page that should still be held, so the sequence of hits and misses in one set is the main test.
- **A valid bit that fails to clear or set:** a hit or miss is wrong on the very next request to that page.
- **A wrong tag or physical page number:** the next hit returns a wrong address.
- **Walker errors:** these show within the same transaction. Symptoms are a read address off by the index scaling, a response in the wrong cycle, or req_ready rising before an abandoned read has drained.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_LOOKUP = 3'd1,
      ST_FETCH  = 3'd2,
      ST_WAIT   = 3'd3,
      ST_DRAIN  = 3'd4
   } walk_state_t;

   localparam int unsigned PTE_W         = 32;
   localparam int unsigned PTE_VALID_BIT = 0;
   localparam int unsigned PTE_BYTES_LOG = 2;

endpackage

// File: rtl/tlb_plru.sv
module tlb_plru #(
   parameter  int unsigned WAYS   = 4,
   localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int unsigned PLRU_W = (WAYS > 1) ? WAYS - 1 : 1
) (
   input  logic [PLRU_W-1:0] plru_i,
   input  logic [WAYS-1:0]   valid_i,
   input  logic [WAY_W-1:0]  use_way_i,
   output logic [WAY_W-1:0]  victim_o,
   output logic [PLRU_W-1:0] plru_next_o
);

   logic             free_found;
   logic [WAY_W-1:0] free_way;
   logic [WAY_W-1:0] tree_way;

   // lowest-numbered empty way wins
   always_comb begin
      free_found = 1'b0;
      free_way   = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!valid_i[w]) begin
            free_found = 1'b1;
            free_way   = w[WAY_W-1:0];
         end
      end
   end

   generate
      if (WAYS == 4) begin : g_tree4
         always_comb begin
            if (plru_i[0]) tree_way = plru_i[2] ? 2'd3 : 2'd2;
            else           tree_way = plru_i[1] ? 2'd1 : 2'd0;
         end
         always_comb begin
            plru_next_o = plru_i;
            if (!use_way_i[1]) begin
               plru_next_o[0] = 1'b1;
               plru_next_o[1] = ~use_way_i[0];
            end else begin
               plru_next_o[0] = 1'b0;
               plru_next_o[2] = ~use_way_i[0];
            end
         end
      end else if (WAYS == 2) begin : g_bit2
         assign tree_way    = plru_i[0];
         assign plru_next_o = ~use_way_i[0];
      end else begin : g_bad_ways
         $error("tlb_plru: WAYS must be 2 or 4");
      end
   endgenerate

   assign victim_o = free_found ? free_way : tree_way;

endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
   parameter  int unsigned SETS   = 16,
   parameter  int unsigned WAYS   = 4,
   parameter  int unsigned TAG_W  = 16,
   parameter  int unsigned PPN_W  = 20,
   localparam int unsigned SET_W  = $clog2(SETS),
   localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int unsigned PLRU_W = (WAYS > 1) ? WAYS - 1 : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic [SET_W-1:0] set_i,
   input  logic [TAG_W-1:0] tag_i,
   output logic             hit_o,
   output logic [PPN_W-1:0] hit_ppn_o,
   input  logic             fill_en_i,
   input  logic [PPN_W-1:0] fill_ppn_i,
   input  logic             touch_en_i,
   input  logic             touch_fill_i
);

   logic [WAYS-1:0]   valid_q [SETS];
   logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
   logic [PPN_W-1:0]  ppn_q   [SETS][WAYS];
   logic [PLRU_W-1:0] plru_q  [SETS];

   logic [WAYS-1:0]   way_hit;
   logic [WAY_W-1:0]  hit_way;
   logic [WAY_W-1:0]  victim_way;
   logic [WAY_W-1:0]  touch_way;
   logic [PLRU_W-1:0] plru_next;

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_cmp
         assign way_hit[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
      end
   endgenerate

   always_comb begin
      hit_way   = '0;
      hit_ppn_o = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (way_hit[w]) begin
            hit_way   = w[WAY_W-1:0];
            hit_ppn_o = ppn_q[set_i][w];
         end
      end
   end

   assign hit_o     = |way_hit;
   assign touch_way = touch_fill_i ? victim_way : hit_way;

   tlb_plru #(.WAYS(WAYS)) u_plru (
      .plru_i      (plru_q[set_i]),
      .valid_i     (valid_q[set_i]),
      .use_way_i   (touch_way),
      .victim_o    (victim_way),
      .plru_next_o (plru_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || flush_i) begin
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            plru_q[s]  <= '0;
         end
      end else begin
         if (fill_en_i)  valid_q[set_i][victim_way] <= 1'b1;
         if (touch_en_i) plru_q[set_i]              <= plru_next;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en_i && !flush_i) begin
         tag_q[set_i][victim_way] <= tag_i;
         ppn_q[set_i][victim_way] <= fill_ppn_i;
      end
   end

endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
   import tlb_pkg::*;
#(
   parameter  int unsigned VA_W   = 32,
   parameter  int unsigned PA_W   = 32,
   parameter  int unsigned PAGE_W = 12,
   localparam int unsigned VPN_W  = VA_W - PAGE_W,
   localparam int unsigned PPN_W  = PA_W - PAGE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             req_valid_i,
   input  logic [VA_W-1:0]  req_vaddr_i,
   output logic             req_ready_o,
   input  logic [PA_W-1:0]  ptbr_i,
   output logic [VPN_W-1:0] vpn_o,
   input  logic             hit_i,
   input  logic [PPN_W-1:0] hit_ppn_i,
   output logic             fill_en_o,
   output logic [PPN_W-1:0] fill_ppn_o,
   output logic             touch_en_o,
   output logic             touch_fill_o,
   output logic             mem_rd_valid_o,
   input  logic             mem_rd_ready_i,
   output logic [PA_W-1:0]  mem_rd_addr_o,
   input  logic             mem_rsp_valid_i,
   input  logic [PTE_W-1:0] mem_rsp_data_i,
   output logic             rsp_valid_o,
   output logic [PA_W-1:0]  rsp_paddr_o,
   output logic             rsp_hit_o,
   output logic             rsp_fault_o
);

   walk_state_t      state_q, state_d;
   logic [VA_W-1:0]  vaddr_q;
   logic [PA_W-1:0]  base_q;
   logic [PA_W-1:0]  pte_off;
   logic             accept;
   logic             hit_done;
   logic             walk_done;
   logic             pte_ok;
   logic [PPN_W-1:0] pte_ppn;
   logic             unused_pte_bits;

   assign accept    = (state_q == ST_IDLE) && req_valid_i && !flush_i;
   assign hit_done  = (state_q == ST_LOOKUP) && hit_i && !flush_i;
   assign walk_done = (state_q == ST_WAIT) && mem_rsp_valid_i && !flush_i;
   assign pte_ok    = mem_rsp_data_i[PTE_VALID_BIT];
   assign pte_ppn   = mem_rsp_data_i[PTE_W-1 -: PPN_W];
   assign unused_pte_bits = ^mem_rsp_data_i[PTE_W-PPN_W-1:PTE_VALID_BIT+1];

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (accept) state_d = ST_LOOKUP;
         ST_LOOKUP: begin
            if (flush_i || hit_i) state_d = ST_IDLE;
            else                  state_d = ST_FETCH;
         end
         ST_FETCH: begin
            if (mem_rd_ready_i) state_d = flush_i ? ST_DRAIN : ST_WAIT;
            else if (flush_i)   state_d = ST_IDLE;
         end
         ST_WAIT: begin
            if (mem_rsp_valid_i) state_d = ST_IDLE;
            else if (flush_i)    state_d = ST_DRAIN;
         end
         ST_DRAIN:  if (mem_rsp_valid_i) state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         vaddr_q <= req_vaddr_i;
         base_q  <= ptbr_i;
      end
   end

   always_comb begin
      pte_off = '0;
      pte_off[VPN_W+PTE_BYTES_LOG-1:0] = {vaddr_q[VA_W-1:PAGE_W], {PTE_BYTES_LOG{1'b0}}};
   end

   assign vpn_o          = vaddr_q[VA_W-1:PAGE_W];
   assign req_ready_o    = (state_q == ST_IDLE) && !flush_i;
   assign mem_rd_valid_o = (state_q == ST_FETCH);
   assign mem_rd_addr_o  = base_q + pte_off;

   assign fill_en_o    = walk_done && pte_ok;
   assign fill_ppn_o   = pte_ppn;
   assign touch_en_o   = hit_done || fill_en_o;
   assign touch_fill_o = fill_en_o;

   assign rsp_valid_o = hit_done || walk_done;
   assign rsp_hit_o   = hit_done;
   assign rsp_fault_o = walk_done && !pte_ok;

   always_comb begin
      if (hit_done)              rsp_paddr_o = {hit_ppn_i, vaddr_q[PAGE_W-1:0]};
      else if (walk_done && pte_ok) rsp_paddr_o = {pte_ppn, vaddr_q[PAGE_W-1:0]};
      else                       rsp_paddr_o = '0;
   end

endmodule

// File: rtl/tlb_sa_refill.sv
module tlb_sa_refill
   import tlb_pkg::*;
#(
   parameter  int unsigned VA_W    = 32,
   parameter  int unsigned PA_W    = 32,
   parameter  int unsigned PAGE_W  = 12,
   parameter  int unsigned ENTRIES = 64,
   parameter  int unsigned WAYS    = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic            req_valid,
   input  logic [VA_W-1:0] req_vaddr,
   output logic            req_ready,
   input  logic [PA_W-1:0] ptbr,
   output logic            rsp_valid,
   output logic [PA_W-1:0] rsp_paddr,
   output logic            rsp_hit,
   output logic            rsp_fault,
   output logic            mem_rd_valid,
   input  logic            mem_rd_ready,
   output logic [PA_W-1:0] mem_rd_addr,
   input  logic            mem_rsp_valid,
   input  logic [31:0]     mem_rsp_data
);

   localparam int unsigned SETS  = ENTRIES / WAYS;
   localparam int unsigned SET_W = $clog2(SETS);
   localparam int unsigned VPN_W = VA_W - PAGE_W;
   localparam int unsigned PPN_W = PA_W - PAGE_W;
   localparam int unsigned TAG_W = VPN_W - SET_W;

   generate
      if (ENTRIES % WAYS != 0) begin : g_chk_div
         $error("tlb_sa_refill: ENTRIES must be a multiple of WAYS");
      end
      if (SETS < 2 || (1 << SET_W) != SETS) begin : g_chk_sets
         $error("tlb_sa_refill: set count must be a power of two >= 2");
      end
      if (TAG_W < 1) begin : g_chk_tag
         $error("tlb_sa_refill: no tag bits left");
      end
      if (PA_W < VPN_W + PTE_BYTES_LOG) begin : g_chk_off
         $error("tlb_sa_refill: PA_W too narrow for table index");
      end
      if (PPN_W + 2 > PTE_W) begin : g_chk_pte
         $error("tlb_sa_refill: page number does not fit the entry format");
      end
   endgenerate

   logic [VPN_W-1:0] vpn;
   logic             hit;
   logic [PPN_W-1:0] hit_ppn;
   logic             fill_en;
   logic [PPN_W-1:0] fill_ppn;
   logic             touch_en;
   logic             touch_fill;

   tlb_store #(
      .SETS  (SETS),
      .WAYS  (WAYS),
      .TAG_W (TAG_W),
      .PPN_W (PPN_W)
   ) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush_i      (flush),
      .set_i        (vpn[SET_W-1:0]),
      .tag_i        (vpn[VPN_W-1:SET_W]),
      .hit_o        (hit),
      .hit_ppn_o    (hit_ppn),
      .fill_en_i    (fill_en),
      .fill_ppn_i   (fill_ppn),
      .touch_en_i   (touch_en),
      .touch_fill_i (touch_fill)
   );

   tlb_walker #(
      .VA_W   (VA_W),
      .PA_W   (PA_W),
      .PAGE_W (PAGE_W)
   ) u_walker (
      .clk             (clk),
      .rst_n           (rst_n),
      .flush_i         (flush),
      .req_valid_i     (req_valid),
      .req_vaddr_i     (req_vaddr),
      .req_ready_o     (req_ready),
      .ptbr_i          (ptbr),
      .vpn_o           (vpn),
      .hit_i           (hit),
      .hit_ppn_i       (hit_ppn),
      .fill_en_o       (fill_en),
      .fill_ppn_o      (fill_ppn),
      .touch_en_o      (touch_en),
      .touch_fill_o    (touch_fill),
      .mem_rd_valid_o  (mem_rd_valid),
      .mem_rd_ready_i  (mem_rd_ready),
      .mem_rd_addr_o   (mem_rd_addr),
      .mem_rsp_valid_i (mem_rsp_valid),
      .mem_rsp_data_i  (mem_rsp_data),
      .rsp_valid_o     (rsp_valid),
      .rsp_paddr_o     (rsp_paddr),
      .rsp_hit_o       (rsp_hit),
      .rsp_fault_o     (rsp_fault)
   );

endmodule

// File: rtl/tlb_sa_refill_chk.sv
module tlb_sa_refill_chk #(
   parameter int unsigned VA_W = 32,
   parameter int unsigned PA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            flush,
   input logic            req_valid,
   input logic [VA_W-1:0] req_vaddr,
   input logic            req_ready,
   input logic [PA_W-1:0] ptbr,
   input logic            rsp_valid,
   input logic [PA_W-1:0] rsp_paddr,
   input logic            rsp_hit,
   input logic            rsp_fault,
   input logic            mem_rd_valid,
   input logic            mem_rd_ready,
   input logic [PA_W-1:0] mem_rd_addr,
   input logic            mem_rsp_valid,
   input logic [31:0]     mem_rsp_data
);

   AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> $past(req_valid && req_ready)); // R2

   AST_READY_LOW_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> (!req_ready && !rsp_valid)); // R3

   AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready && !flush) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R3

   AST_WALK_RSP_WITH_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> mem_rsp_valid); // R4

   AST_RSP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot0({rsp_hit, rsp_fault})); // R4

   AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_hit && !rsp_fault)); // R5

   AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_paddr == '0)); // R5

   AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (!req_ready && !rsp_valid)); // R11

endmodule

bind tlb_sa_refill tlb_sa_refill_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/tlb_sa_refill_tb.sv
module tlb_sa_refill_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] BASE = 32'h0010_0000;

   typedef struct packed {
      logic [31:0] va;
      logic [31:0] pte;
      logic        miss;
      logic        fault;
      logic [31:0] pa;
      logic [31:0] maddr;
      logic [3:0]  lat;
   } vec_t;

   localparam int NVEC = 16;
   localparam vec_t VEC [NVEC] = '{
      '{32'h0000_1234, 32'hABCD_E001, 1'b1, 1'b0, 32'hABCD_E234, 32'h0010_0004, 4'd0}, // R3 R4 first fill set 1
      '{32'h0000_1FFC, 32'h0,         1'b0, 1'b0, 32'hABCD_EFFC, 32'h0,         4'd0}, // R2 hit
      '{32'h0001_1000, 32'h1234_5001, 1'b1, 1'b0, 32'h1234_5000, 32'h0010_0044, 4'd2}, // R6 R7 way1
      '{32'h0002_1008, 32'h2222_2001, 1'b1, 1'b0, 32'h2222_2008, 32'h0010_0084, 4'd1}, // R7 way2
      '{32'h0003_1010, 32'h3333_3001, 1'b1, 1'b0, 32'h3333_3010, 32'h0010_00C4, 4'd3}, // R7 way3
      '{32'h0000_1000, 32'h0,         1'b0, 1'b0, 32'hABCD_E000, 32'h0,         4'd0}, // R6 R8 touch way0
      '{32'h0004_1000, 32'h4444_4001, 1'b1, 1'b0, 32'h4444_4000, 32'h0010_0104, 4'd0}, // R8 evict way2
      '{32'h0000_1004, 32'h0,         1'b0, 1'b0, 32'hABCD_E004, 32'h0,         4'd0}, // R8 way0 kept
      '{32'h0001_1008, 32'h0,         1'b0, 1'b0, 32'h1234_5008, 32'h0,         4'd0}, // R8 way1 kept
      '{32'h0003_100C, 32'h0,         1'b0, 1'b0, 32'h3333_300C, 32'h0,         4'd0}, // R8 way3 kept
      '{32'h0004_1FF0, 32'h0,         1'b0, 1'b0, 32'h4444_4FF0, 32'h0,         4'd0}, // R8 new entry
      '{32'h0002_1000, 32'h2222_2001, 1'b1, 1'b0, 32'h2222_2000, 32'h0010_0084, 4'd1}, // R8 was evicted
      '{32'h0000_1000, 32'hABCD_E001, 1'b1, 1'b0, 32'hABCD_E000, 32'h0010_0004, 4'd0}, // R8 tree chose way0
      '{32'h0000_5000, 32'h7777_7000, 1'b1, 1'b1, 32'h0,         32'h0010_0014, 4'd2}, // R5 fault
      '{32'h0000_5010, 32'h7777_7001, 1'b1, 1'b0, 32'h7777_7010, 32'h0010_0014, 4'd0}, // R5 not installed
      '{32'h0000_5ABC, 32'h0,         1'b0, 1'b0, 32'h7777_7ABC, 32'h0,         4'd0}  // R4 now hits
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_ready;
   logic [31:0] ptbr = BASE;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic        rsp_hit;
   logic        rsp_fault;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b0;
   logic [31:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tlb_sa_refill u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .flush         (flush),
      .req_valid     (req_valid),
      .req_vaddr     (req_vaddr),
      .req_ready     (req_ready),
      .ptbr          (ptbr),
      .rsp_valid     (rsp_valid),
      .rsp_paddr     (rsp_paddr),
      .rsp_hit       (rsp_hit),
      .rsp_fault     (rsp_fault),
      .mem_rd_valid  (mem_rd_valid),
      .mem_rd_ready  (mem_rd_ready),
      .mem_rd_addr   (mem_rd_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic xlate(input logic [31:0] va, input logic [31:0] pte, input int lat,
                        output logic got, output logic h, output logic f,
                        output logic [31:0] pa, output logic saw, output logic [31:0] ma,
                        output logic rdy_ok, output int cyc);
      got = 0; h = 0; f = 0; pa = '0; saw = 0; ma = '0; rdy_ok = 1; cyc = 0;
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0;
      for (int c = 0; c < 64 && !got; c++) begin
         #1;
         if (rsp_valid) begin
            got = 1; h = rsp_hit; f = rsp_fault; pa = rsp_paddr; cyc = c;
         end else begin
            if (req_ready) rdy_ok = 0;
            if (mem_rd_valid) begin
               saw = 1;
               ma  = mem_rd_addr;
               mem_rd_ready = 1'b1;
               @(negedge clk);
               mem_rd_ready = 1'b0;
               for (int l = 0; l < lat; l++) begin
                  #1;
                  if (req_ready || rsp_valid) rdy_ok = 0;
                  @(negedge clk);
               end
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = pte;
               #1;
               if (rsp_valid) begin
                  got = 1; h = rsp_hit; f = rsp_fault; pa = rsp_paddr; cyc = c;
               end
               @(negedge clk);
               mem_rsp_valid = 1'b0;
            end else begin
               @(negedge clk);
            end
         end
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic got, h, f, saw, rdy_ok;
      logic [31:0] pa, ma;
      int cyc;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 req_ready after reset", {31'b0, req_ready}, 32'd1);
      check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
      check("R1 mem_rd_valid after reset", {31'b0, mem_rd_valid}, 32'd0);

      // table walk: fills, hits, pseudo-LRU eviction order, faults
      for (int i = 0; i < NVEC; i++) begin
         xlate(VEC[i].va, VEC[i].pte, int'(VEC[i].lat), got, h, f, pa, saw, ma, rdy_ok, cyc);
         check($sformatf("R2/R4 vec%0d response seen", i), {31'b0, got}, 32'd1);
         check($sformatf("R2/R3 vec%0d memory read issued", i), {31'b0, saw}, {31'b0, VEC[i].miss});
         check($sformatf("R2/R4 vec%0d hit flag", i), {31'b0, h}, {31'b0, ~VEC[i].miss});
         check($sformatf("R5 vec%0d fault flag", i), {31'b0, f}, {31'b0, VEC[i].fault});
         check($sformatf("R2/R4 vec%0d paddr", i), pa, VEC[i].pa);
         if (VEC[i].miss) begin
            check($sformatf("R3 vec%0d table address", i), ma, VEC[i].maddr);
            check($sformatf("R3 vec%0d ready low in walk", i), {31'b0, rdy_ok}, 32'd1);
         end else begin
            check($sformatf("R2 vec%0d one-cycle hit", i), cyc, 32'd0);
         end
      end

      // R11 / R9: flush blocks acceptance and empties the buffer
      @(negedge clk);
      flush = 1'b1;
      req_valid = 1'b1;
      req_vaddr = 32'h0000_5ABC;
      #1;
      check("R11 req_ready low during flush", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
      flush = 1'b0;
      req_valid = 1'b0;
      #1;
      check("R11 no response from request during flush", {31'b0, rsp_valid}, 32'd0);
      xlate(32'h0000_5ABC, 32'h7777_7001, 1, got, h, f, pa, saw, ma, rdy_ok, cyc);
      check("R9 held page misses after flush", {31'b0, saw}, 32'd1);
      check("R9 refill after flush paddr", pa, 32'h7777_7ABC);
      xlate(32'h0000_1000, 32'hABCD_E001, 0, got, h, f, pa, saw, ma, rdy_ok, cyc);
      check("R9 set1 page misses after flush", {31'b0, saw}, 32'd1);

      // R10: flush after the read was accepted, response must be drained
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = 32'h0000_6000;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      #1;
      check("R10 read issued before abort", {31'b0, mem_rd_valid}, 32'd1);
      mem_rd_ready = 1'b1;
      @(negedge clk);
      mem_rd_ready = 1'b0;
      flush = 1'b1;
      #1;
      check("R10 no response on abort", {31'b0, rsp_valid}, 32'd0);
      @(negedge clk);
      flush = 1'b0;
      #1;
      check("R10 ready low while draining", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 32'h6666_6001;
      #1;
      check("R10 drained response discarded", {31'b0, rsp_valid}, 32'd0);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      #1;
      check("R10 ready back after drain", {31'b0, req_ready}, 32'd1);
      xlate(32'h0000_6000, 32'h6666_6001, 0, got, h, f, pa, saw, ma, rdy_ok, cyc);
      check("R10 aborted entry not installed", {31'b0, saw}, 32'd1);
      check("R10 retry table address", ma, 32'h0010_0018);
      check("R10 retry paddr", pa, 32'h6666_6000);

      // R10: flush while the read is still waiting for acceptance
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = 32'h0000_7000;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      flush = 1'b1;
      #1;
      check("R10 read pending at abort", {31'b0, mem_rd_valid}, 32'd1);
      check("R10 no response on early abort", {31'b0, rsp_valid}, 32'd0);
      @(negedge clk);
      flush = 1'b0;
      #1;
      check("R10 read withdrawn after abort", {31'b0, mem_rd_valid}, 32'd0);
      check("R10 ready after early abort", {31'b0, req_ready}, 32'd1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule